// File: doc/BRIEF.md
# SDRAM Power-Down Sequencer

This controller-side block decides when an SDRAM may drop its clock enable to save power, and brings the device back out. While a power-down request is held, no access is running and no refresh is pending, it lowers CKE. At the same time it forces the command slot to NOP, so the device sees a valid entry. It samples the any-bank-open flag at entry and reports the kind of power-down: precharge power-down when every bank is idle, active power-down when a row is open.

The time spent with CKE low is capped by a cycle-count limit. This keeps the device from sleeping through its refresh period. An exit is also forced at once when refresh becomes due or when the request is withdrawn. Each exit raises CKE while the NOP override stays in force for a set number of cycles. Only then is the command bus handed back to the scheduler. Issuing refresh and tracking banks are the job of neighbouring logic.

Top module: `sdram_pd_seq`

## Requirements
- R1: After reset, cke is 1, force_nop is 0 and pd_mode is 0 (awake).
- R2: When the block is awake and not in its exit window, pd_req is 1, access_busy is 0 and refresh_due is 0 at a clock edge, then from that edge on cke is 0 and force_nop is 1.
- R3: While access_busy is 1, power-down is not entered and cke stays 1. A request still held when access_busy falls is entered at the next edge.
- R4: pd_mode is 1 (precharge power-down) when bank_open was 0 at entry, and 2 (active power-down) when it was 1. The value does not change with bank_open while in power-down.
- R5: cke stays 0 for no more than MAX_PD_CYCLES consecutive cycles. With the request held and no refresh due, it rises after exactly MAX_PD_CYCLES cycles.
- R6: refresh_due at 1 while in power-down raises cke at the next edge. refresh_due at 1 while awake prevents entry.
- R7: Dropping pd_req while in power-down raises cke at the next edge.
- R8: After every exit, cke is 1, pd_mode is 0 and force_nop is 1 for exactly EXIT_NOP_CYCLES cycles, then force_nop returns to 0. pd_req during this window does not lower cke.
- R9: Whenever cke is 0, force_nop is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_req | input | 1 | Level request to stay in power-down |
| access_busy | input | 1 | A read or write burst is in progress |
| bank_open | input | 1 | At least one bank holds an open row |
| refresh_due | input | 1 | Refresh must be issued soon |
| cke | output | 1 | Clock enable to the SDRAM |
| force_nop | output | 1 | Command slot must carry NOP |
| pd_mode | output | 2 | 0 awake, 1 precharge power-down, 2 active power-down |

## Verification
The assertions take it for granted that access_busy, bank_open and refresh_due come from a scheduler that starts no access while force_nop is high. They also assume refresh_due, once raised, is left for the refresh logic to serve. The bench keeps to this. It changes inputs only on the falling edge, holds access_busy low whenever power-down is under way, and clears refresh_due before asking for the next entry. A shortened cap of 40 cycles lets the timeout exit be counted cycle by cycle.

// File: rtl/sdram_pd_seq.sv
module sdram_pd_seq #(
  parameter int MAX_PD_CYCLES   = 3_200_000,
  parameter int EXIT_NOP_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pd_req,
  input  logic       access_busy,
  input  logic       bank_open,
  input  logic       refresh_due,
  output logic       cke,
  output logic       force_nop,
  output logic [1:0] pd_mode
);
  localparam int TW = $clog2(MAX_PD_CYCLES + 1);
  localparam int XW = $clog2(EXIT_NOP_CYCLES + 1);

  typedef enum logic [1:0] {AWAKE, SLEEP, WAKE} st_t;
  st_t st;
  logic [TW-1:0] tmr;
  logic [XW-1:0] xcnt;
  logic          open_at_entry;

  wire enter    = (st == AWAKE) && pd_req && !access_busy && !refresh_due;
  wire timeout  = (tmr == TW'(MAX_PD_CYCLES - 1));
  wire leave    = (st == SLEEP) && (!pd_req || refresh_due || timeout);
  wire wake_end = (st == WAKE) && (xcnt == XW'(EXIT_NOP_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= AWAKE;
      tmr           <= '0;
      xcnt          <= '0;
      open_at_entry <= 1'b0;
    end else begin
      case (st)
        AWAKE: if (enter) begin
          st            <= SLEEP;
          tmr           <= '0;
          open_at_entry <= bank_open;
        end
        SLEEP: if (leave) begin
          st   <= WAKE;
          xcnt <= '0;
        end else begin
          tmr <= tmr + 1'b1;
        end
        WAKE: if (wake_end) st <= AWAKE;
              else          xcnt <= xcnt + 1'b1;
        default: st <= AWAKE;
      endcase
    end
  end

  assign cke       = (st != SLEEP);
  assign force_nop = (st != AWAKE);
  assign pd_mode   = (st != SLEEP) ? 2'd0 : (open_at_entry ? 2'd2 : 2'd1);
endmodule

module sdram_pd_seq_chk #(
  parameter int MAX_PD_CYCLES = 3_200_000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pd_req,
  input logic       access_busy,
  input logic       refresh_due,
  input logic       cke,
  input logic       force_nop,
  input logic [1:0] pd_mode
);
  logic [31:0] low_run;
  always_ff @(posedge clk) begin
    if (!rst_n)   low_run <= '0;
    else if (cke) low_run <= '0;
    else          low_run <= low_run + 1'b1;
  end

  p_nop_when_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> force_nop);
  p_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && !force_nop && pd_req && !access_busy && !refresh_due) |=> !cke);
  p_busy_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && access_busy) |=> cke);
  p_mode_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> (cke || $stable(pd_mode)));
  p_mode_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (pd_mode == 2'd1 || pd_mode == 2'd2));
  p_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (low_run < 32'(MAX_PD_CYCLES)));
  p_refresh_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && refresh_due) |=> cke);
  p_refresh_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && refresh_due) |=> cke);
  p_release_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && !pd_req) |=> cke);
  p_awake_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cke |-> (pd_mode == 2'd0));
  p_exit_nop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke) |=> (cke -> force_nop));
endmodule

bind sdram_pd_seq sdram_pd_seq_chk #(.MAX_PD_CYCLES(MAX_PD_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .access_busy(access_busy),
  .refresh_due(refresh_due), .cke(cke), .force_nop(force_nop), .pd_mode(pd_mode)
);

// File: tb/sim_sdram_pd_seq.sv
module sim_sdram_pd_seq;
  localparam int MAXPD = 40;
  localparam int XNOP  = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pd_req = 1'b0, access_busy = 1'b0, bank_open = 1'b0, refresh_due = 1'b0;
  logic cke, force_nop;
  logic [1:0] pd_mode;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sdram_pd_seq #(.MAX_PD_CYCLES(MAXPD), .EXIT_NOP_CYCLES(XNOP)) u0 (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .access_busy(access_busy),
    .bank_open(bank_open), .refresh_due(refresh_due),
    .cke(cke), .force_nop(force_nop), .pd_mode(pd_mode)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_out(string req, int c, int n, int m);
    chk({req, " cke"}, int'(cke), c);
    chk({req, " force_nop"}, int'(force_nop), n);
    chk({req, " pd_mode"}, int'(pd_mode), m);
  endtask

  task automatic exit_window(string req);
    for (int i = 0; i < XNOP; i++) begin
      chk_out(req, 1, 1, 0);
      step();
    end
    chk({req, " bus released"}, int'(force_nop), 0);
  endtask

  task automatic t_reset();
    chk_out("R1 reset", 1, 0, 0);
  endtask

  task automatic t_precharge_pd();
    bank_open = 1'b0; pd_req = 1'b1;
    step();
    chk_out("R2 entry precharge", 0, 1, 1);
    bank_open = 1'b1;
    step();
    chk("R4 mode held against bank_open", int'(pd_mode), 1);
    pd_req = 1'b0;
    step();
    chk_out("R7 release exit", 1, 1, 0);
    pd_req = 1'b1;
    step();
    chk("R8 request ignored in exit", int'(cke), 1);
    chk("R8 nop in exit", int'(force_nop), 1);
    pd_req = 1'b0;
    step();
    chk("R8 nop last exit cycle", int'(force_nop), 1);
    step();
    chk("R8 bus released", int'(force_nop), 0);
  endtask

  task automatic t_active_refresh();
    bank_open = 1'b1; pd_req = 1'b1;
    step();
    chk_out("R4 active entry", 0, 1, 2);
    refresh_due = 1'b1;
    step();
    refresh_due = 1'b0; pd_req = 1'b0;
    exit_window("R6 refresh forced exit");
  endtask

  task automatic t_busy_hold();
    bank_open = 1'b0; access_busy = 1'b1; pd_req = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step();
      chk_out("R3 held while busy", 1, 0, 0);
    end
    access_busy = 1'b0;
    step();
    chk_out("R3 entry after busy", 0, 1, 1);
    pd_req = 1'b0;
    step();
    exit_window("R7 exit after busy case");
  endtask

  task automatic t_refresh_block();
    refresh_due = 1'b1; pd_req = 1'b1;
    step();
    step();
    chk_out("R6 refresh blocks entry", 1, 0, 0);
    refresh_due = 1'b0; pd_req = 1'b0;
    step();
  endtask

  task automatic t_timeout();
    int lows = 0;
    pd_req = 1'b1;
    step();
    while (!cke && lows < 5 * MAXPD) begin
      chk("R9 nop while cke low", int'(force_nop), 1);
      lows++;
      step();
    end
    pd_req = 1'b0;
    chk("R5 cycles in power-down", lows, MAXPD);
    exit_window("R5 timeout exit");
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_precharge_pd();
    t_active_refresh();
    t_busy_hold();
    t_refresh_block();
    t_timeout();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule